// File: doc/BRIEF.md
# Link-Side Packet Transmit Handshake Controller

This controller lives on the link side of a parallel PHY-to-link interface. The interface has a 2-bit control bus, an 8-bit data bus and one shared clock. While the PHY owns the interface, the controller listens for a grant. A grant is the PHY driving the control bus to 11 for one clock, followed by one idle clock. In the grant clock the controller decodes the format bit, the grant type and the speed, and compares all three with its own pending request. It takes the interface only when every field matches. Otherwise the bus is left to the PHY.

Once it owns the interface, the controller can drive hold while the payload is still being prepared. It then streams bytes from a valid/ready source, driving transmit on every byte. It closes the packet in one of two ways. If a follow-on request is pending or the packet ends a subaction, it drives a closing hold cycle that carries the follow-on request and the subaction-end flag, then one idle cycle. Otherwise it drives a single idle cycle. After that it releases both buses. If neither hold nor data is ready in time after a grant, the controller abandons the attempt without touching the bus.

States:
- `ST_IDLE`: the PHY owns the bus.
- `ST_GAP`: the idle clock after an accepted grant.
- `ST_CLAIM`: waiting for payload or for a hold request, with the bus undriven.
- `ST_HOLD`: driving hold while the payload is prepared.
- `ST_XMIT`: driving transmit with one byte per cycle.
- `ST_CLOSE_HOLD`: the closing hold cycle that carries the follow-on request.
- `ST_CLOSE_IDLE`: the final driven idle cycle.

Transitions:
- IDLE→GAP: a matching grant is seen.
- GAP→CLAIM: the PHY drives idle after the grant.
- GAP→IDLE: the PHY does not drive idle after the grant.
- CLAIM→XMIT: payload is valid.
- CLAIM→HOLD: a hold is requested.
- CLAIM→IDLE: the window expires; this is the abandon path.
- HOLD→XMIT: payload is valid.
- XMIT→XMIT: the next byte is accepted.
- XMIT→CLOSE_HOLD or XMIT→CLOSE_IDLE: the packet has ended.
- CLOSE_HOLD→CLOSE_IDLE: always.
- CLOSE_IDLE→IDLE: always.

Top module: `lnk_tx_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `lk_ctl_oe`, `lk_d_oe`, `tx_done`, `tx_abandon` and `pl_ready` are all 0.
- R2: A grant is a cycle in which `phy_ctl` is 11 while the link is not driving. It is accepted only when all of the following hold. `req_valid` is 1. `phy_d[0]` equals `req_beta`. `phy_d[3:1]` equals `req_kind` and is one of 010, 101, 110 or 111. `phy_d[6:5]` equals `req_rate`. The next cycle has `phy_ctl` = 00. `phy_d[4]` and `phy_d[7]` are not compared. A rejected grant leaves both enables at 0 and raises no `tx_abandon`, even if payload and hold are offered.
- R3: The first driven cycle comes after the post-grant idle clock. If `hold_req` was chosen first, the link drives `lk_ctl` = 11 with `lk_d` = 00 for every cycle until payload is valid. If payload was valid first, the first driven cycle is already transmit with the first byte.
- R4: Each byte accepted on the payload stream appears once, in order, on `lk_d` in a cycle with `lk_ctl` = 01. Both output enables always switch together.
- R5: The packet closes with a hold cycle when `nx_kind` ≠ 000 or `sub_end` = 1. In that cycle `lk_ctl` = 11 and `lk_d` carries `nx_beta` in bit 0, `nx_kind` in bits 3:1, `sub_end` in bit 4, `nx_rate` in bits 6:5 and 0 in bit 7. Exactly one cycle of `lk_ctl` = 00 with `lk_d` = 00 follows, then both enables drop.
- R6: When no closing hold is needed, the last transmit cycle is followed directly by one driven idle cycle (00, data 00), then both enables drop.
- R7: The link must drive within `GRANT_WIN` (8) clocks of the grant clock. If neither `pl_valid` nor `hold_req` has appeared by the last claim cycle, `tx_abandon` pulses for one cycle. That pulse falls in the 8th clock after the grant clock, and the bus is never driven.
- R8: If `pl_valid` drops during transmit before a byte marked `pl_last`, the packet closes at once, exactly as after a last byte.
- R9: `tx_done` is 1 only in the final driven idle cycle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_ctl | input | 2 | Control bus as driven by the PHY |
| phy_d | input | 8 | Data bus as driven by the PHY |
| req_valid | input | 1 | A request is pending |
| req_beta | input | 1 | Requested format bit |
| req_kind | input | 3 | Requested grant type |
| req_rate | input | 2 | Requested speed code |
| hold_req | input | 1 | Claim the bus with hold while payload is prepared |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Payload byte is the last of the packet |
| pl_ready | output | 1 | Payload byte accepted this cycle |
| nx_kind | input | 3 | Follow-on request type for the closing hold |
| nx_rate | input | 2 | Follow-on speed code |
| nx_beta | input | 1 | Follow-on format bit |
| sub_end | input | 1 | Packet ends a subaction |
| lk_ctl | output | 2 | Control value driven by the link |
| lk_ctl_oe | output | 1 | Enable for the control bus |
| lk_d | output | 8 | Data value driven by the link |
| lk_d_oe | output | 1 | Enable for the data bus |
| tx_done | output | 1 | Final idle cycle of a packet |
| tx_abandon | output | 1 | Grant given up after the window expired |

## Verification
Matching grants are tried with each of the four accepted grant types and all four speeds. The runs mix direct transmit, a hold phase of one or several cycles, and start points from the first claim cycle up to the last legal one, which shows the exact window limit. Rejected grants are offered with payload and hold both pending, so that any wrong claim would show on the enables. The rejected cases differ in only one field each: speed, format, type, a reserved type, a withdrawn request, or a non-idle clock after the grant. Closing is tried with no trailer, with a follow-on request, with the subaction flag alone, and after a source underrun. This separates the encoding of every trailer field and the choice between a hold close and an idle close.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

    localparam logic [1:0] CTL_IDLE = 2'b00;
    localparam logic [1:0] CTL_XMIT = 2'b01;
    localparam logic [1:0] CTL_HOLD = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_CLAIM,
        ST_HOLD,
        ST_XMIT,
        ST_CLOSE_HOLD,
        ST_CLOSE_IDLE
    } tx_state_e;

    typedef struct packed {
        logic [1:0] rate;
        logic [2:0] kind;
        logic       beta;
    } xfer_attr_t;

    // grant types the link may act on; the rest are reserved
    function automatic logic kind_usable(input logic [2:0] k);
        return (k == 3'b010) || (k == 3'b101) || (k == 3'b110) || (k == 3'b111);
    endfunction

endpackage

// File: rtl/lnk_grant_match.sv
module lnk_grant_match
    import lnk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] phy_d,
    input  logic              req_valid,
    input  xfer_attr_t        want,
    output logic              match
);
    xfer_attr_t seen;

    always_comb begin
        seen.beta = phy_d[0];
        seen.kind = phy_d[3:1];
        seen.rate = phy_d[6:5];
        match     = req_valid && kind_usable(seen.kind) && (seen == want);
    end
endmodule

// File: rtl/lnk_claim_timer.sv
module lnk_claim_timer #(
    parameter int GRANT_WIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    // grant clock and gap clock use two of the window
    localparam int CLAIM_MAX = GRANT_WIN - 2;
    localparam int CW        = $clog2(GRANT_WIN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(CLAIM_MAX - 1));
endmodule

// File: rtl/lnk_trailer_enc.sv
module lnk_trailer_enc
    import lnk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  xfer_attr_t        next_req,
    input  logic              sub_end,
    output logic [DATA_W-1:0] trailer,
    output logic              need_hold
);
    always_comb begin
        trailer      = '0;
        trailer[0]   = next_req.beta;
        trailer[3:1] = next_req.kind;
        trailer[4]   = sub_end;
        trailer[6:5] = next_req.rate;
        need_hold    = (next_req.kind != 3'b000) || sub_end;
    end
endmodule

// File: rtl/lnk_tx_ctrl.sv
module lnk_tx_ctrl
    import lnk_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int GRANT_WIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        phy_ctl,
    input  logic [DATA_W-1:0] phy_d,
    input  logic              req_valid,
    input  logic              req_beta,
    input  logic [2:0]        req_kind,
    input  logic [1:0]        req_rate,
    input  logic              hold_req,
    input  logic              pl_valid,
    input  logic [DATA_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              pl_ready,
    input  logic [2:0]        nx_kind,
    input  logic [1:0]        nx_rate,
    input  logic              nx_beta,
    input  logic              sub_end,
    output logic [1:0]        lk_ctl,
    output logic              lk_ctl_oe,
    output logic [DATA_W-1:0] lk_d,
    output logic              lk_d_oe,
    output logic              tx_done,
    output logic              tx_abandon
);
    tx_state_e         state, nxt;
    xfer_attr_t        want, follow;
    logic              match, expired, need_hold, last_q, abandon_n;
    logic [DATA_W-1:0] trailer;

    logic [1:0]        ctl_n;
    logic [DATA_W-1:0] d_n;
    logic              oe_n, done_n;

    assign want   = '{rate: req_rate, kind: req_kind, beta: req_beta};
    assign follow = '{rate: nx_rate,  kind: nx_kind,  beta: nx_beta};

    lnk_grant_match #(.DATA_W(DATA_W)) u_match (
        .phy_d     (phy_d),
        .req_valid (req_valid),
        .want      (want),
        .match     (match)
    );

    lnk_claim_timer #(.GRANT_WIN(GRANT_WIN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_CLAIM),
        .expired (expired)
    );

    lnk_trailer_enc #(.DATA_W(DATA_W)) u_trl (
        .next_req  (follow),
        .sub_end   (sub_end),
        .trailer   (trailer),
        .need_hold (need_hold)
    );

    // next-state and stream handshake
    always_comb begin
        nxt       = state;
        pl_ready  = 1'b0;
        abandon_n = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (phy_ctl == CTL_HOLD && match) nxt = ST_GAP;
            end
            ST_GAP: begin
                nxt = (phy_ctl == CTL_IDLE) ? ST_CLAIM : ST_IDLE;
            end
            ST_CLAIM: begin
                if (pl_valid) begin
                    pl_ready = 1'b1;
                    nxt      = ST_XMIT;
                end else if (hold_req) begin
                    nxt = ST_HOLD;
                end else if (expired) begin
                    nxt       = ST_IDLE;
                    abandon_n = 1'b1;
                end
            end
            ST_HOLD: begin
                if (pl_valid) begin
                    pl_ready = 1'b1;
                    nxt      = ST_XMIT;
                end
            end
            ST_XMIT: begin
                if (!last_q && pl_valid) begin
                    pl_ready = 1'b1;
                end else begin
                    nxt = need_hold ? ST_CLOSE_HOLD : ST_CLOSE_IDLE;
                end
            end
            ST_CLOSE_HOLD: nxt = ST_CLOSE_IDLE;
            ST_CLOSE_IDLE: nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // last-byte marker for the packet in flight
    always_ff @(posedge clk) begin
        if (rst)                        last_q <= 1'b0;
        else if (pl_valid && pl_ready)  last_q <= pl_last;
        else if (state != ST_XMIT)      last_q <= 1'b0;
    end

    // bus values for the cycle the next state occupies
    always_comb begin
        ctl_n  = CTL_IDLE;
        d_n    = '0;
        oe_n   = 1'b0;
        done_n = 1'b0;
        unique case (nxt)
            ST_HOLD: begin
                oe_n  = 1'b1;
                ctl_n = CTL_HOLD;
            end
            ST_XMIT: begin
                oe_n  = 1'b1;
                ctl_n = CTL_XMIT;
                d_n   = pl_data;
            end
            ST_CLOSE_HOLD: begin
                oe_n  = 1'b1;
                ctl_n = CTL_HOLD;
                d_n   = trailer;
            end
            ST_CLOSE_IDLE: begin
                oe_n   = 1'b1;
                done_n = 1'b1;
            end
            default: ;
        endcase
    end

    // registered outputs and enables
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_ctl     <= CTL_IDLE;
            lk_d       <= '0;
            lk_ctl_oe  <= 1'b0;
            lk_d_oe    <= 1'b0;
            tx_done    <= 1'b0;
            tx_abandon <= 1'b0;
        end else begin
            lk_ctl     <= ctl_n;
            lk_d       <= d_n;
            lk_ctl_oe  <= oe_n;
            lk_d_oe    <= oe_n;
            tx_done    <= done_n;
            tx_abandon <= abandon_n;
        end
    end
endmodule

// File: rtl/lnk_tx_ctrl_chk.sv
module lnk_tx_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phy_ctl,
    input logic [1:0]        lk_ctl,
    input logic              lk_ctl_oe,
    input logic [DATA_W-1:0] lk_d,
    input logic              lk_d_oe,
    input logic              tx_done,
    input logic              tx_abandon
);
    a_r2_no_drive_after_grant: assert property (@(posedge clk) disable iff (rst)
        (!lk_ctl_oe && phy_ctl == 2'b11) |=> !lk_ctl_oe);

    a_r3_first_drive_kind: assert property (@(posedge clk) disable iff (rst)
        $rose(lk_ctl_oe) |-> (lk_ctl == 2'b11 || lk_ctl == 2'b01));

    a_r3_prep_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (lk_ctl_oe && lk_ctl == 2'b11 && !($past(lk_ctl_oe) && $past(lk_ctl) == 2'b01))
        |-> lk_d == '0);

    a_r4_enables_paired: assert property (@(posedge clk) disable iff (rst)
        lk_ctl_oe == lk_d_oe);

    a_r5_close_hold_then_idle: assert property (@(posedge clk) disable iff (rst)
        (lk_ctl_oe && lk_ctl == 2'b11 && $past(lk_ctl_oe) && $past(lk_ctl) == 2'b01)
        |=> (lk_ctl_oe && lk_ctl == 2'b00 && lk_d == '0));

    a_r6_idle_then_release: assert property (@(posedge clk) disable iff (rst)
        (lk_ctl_oe && lk_ctl == 2'b00) |=> !lk_ctl_oe);

    a_r7_abandon_quiet: assert property (@(posedge clk) disable iff (rst)
        tx_abandon |-> (!lk_ctl_oe && !tx_done));

    a_r9_done_in_idle: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (lk_ctl_oe && lk_ctl == 2'b00));
endmodule

bind lnk_tx_ctrl lnk_tx_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phy_ctl    (phy_ctl),
    .lk_ctl     (lk_ctl),
    .lk_ctl_oe  (lk_ctl_oe),
    .lk_d       (lk_d),
    .lk_d_oe    (lk_d_oe),
    .tx_done    (tx_done),
    .tx_abandon (tx_abandon)
);

// File: tb/lnk_tx_ctrl_test.sv
module lnk_tx_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int M          = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] phy_ctl = 2'b00;
    logic [7:0] phy_d = '0;
    logic       req_valid = 1'b0, req_beta = 1'b0;
    logic [2:0] req_kind = '0;
    logic [1:0] req_rate = '0;
    logic       hold_req = 1'b0, pl_valid = 1'b0, pl_last = 1'b0;
    logic [7:0] pl_data = '0;
    logic       pl_ready;
    logic [2:0] nx_kind = '0;
    logic [1:0] nx_rate = '0;
    logic       nx_beta = 1'b0, sub_end = 1'b0;
    logic [1:0] lk_ctl;
    logic       lk_ctl_oe, lk_d_oe, tx_done, tx_abandon;
    logic [7:0] lk_d;

    int  n_chk = 0, n_bad = 0;
    bit  ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_tx_ctrl uut (
        .clk(clk), .rst(rst), .phy_ctl(phy_ctl), .phy_d(phy_d),
        .req_valid(req_valid), .req_beta(req_beta), .req_kind(req_kind), .req_rate(req_rate),
        .hold_req(hold_req), .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
        .pl_ready(pl_ready), .nx_kind(nx_kind), .nx_rate(nx_rate), .nx_beta(nx_beta),
        .sub_end(sub_end), .lk_ctl(lk_ctl), .lk_ctl_oe(lk_ctl_oe), .lk_d(lk_d),
        .lk_d_oe(lk_d_oe), .tx_done(tx_done), .tx_abandon(tx_abandon)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int i);
        return 8'(8'hA5 ^ (i * 29));
    endfunction

    task automatic quiet_inputs();
        hold_req = 0; pl_valid = 0; pl_last = 0; pl_data = '0;
        phy_ctl = 2'b00; phy_d = '0; req_valid = 0;
    endtask

    task automatic do_grant(input logic [7:0] g, input logic [1:0] after_ctl);
        @(negedge clk); phy_ctl = 2'b11; phy_d = g;
        @(negedge clk); phy_ctl = after_ctl; phy_d = '0;
        if (after_ctl != 2'b00) begin
            @(negedge clk); phy_ctl = 2'b00;
        end
    endtask

    // R1
    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1", "enables in reset", {30'b0, lk_ctl_oe, lk_d_oe}, 0);
        rst = 0;
        @(negedge clk);
        check("R1", "outputs after reset", {28'b0, lk_ctl_oe, tx_done, tx_abandon, pl_ready}, 0);
    endtask

    // R2..R6, R8, R9: full packet with measured trace
    task automatic t_pkt(input string tag, input logic [2:0] kind, input logic [1:0] rate,
                         input logic beta, input int wait_c, input int hold_c, input int n,
                         input bit use_last, input logic [2:0] nk, input logic [1:0] nr,
                         input logic nb, input logic se);
        logic       ro[M]; logic [1:0] rc[M]; logic [7:0] rd[M]; logic rdone[M];
        int idx, base, k;
        bit trl;
        logic [7:0] trailer;
        req_valid = 1; req_kind = kind; req_rate = rate; req_beta = beta;
        nx_kind = nk; nx_rate = nr; nx_beta = nb; sub_end = se;
        // bits 7 and 4 set: must be ignored (R2)
        do_grant({1'b1, rate, 1'b1, kind, beta}, 2'b00);
        idx = 0;
        for (int c = 0; c < M; c++) begin
            @(negedge clk);
            ro[c] = lk_ctl_oe; rc[c] = lk_ctl; rd[c] = lk_d; rdone[c] = tx_done;
            hold_req = 0; pl_valid = 0; pl_last = 0;
            if (c >= wait_c && c < wait_c + hold_c) begin
                hold_req = (c == wait_c);
            end else if (c >= wait_c + hold_c && idx < n) begin
                pl_valid = 1; pl_data = byte_of(idx);
                pl_last = use_last && (idx == n - 1);
                #1;
                if (pl_ready) idx++;
            end
        end
        req_valid = 0;
        base = wait_c + 1;
        trl = (nk != 3'b000) || se;
        trailer = {1'b0, nr, se, nk, nb};
        for (int c = 0; c < M; c++) begin
            if (c < base) begin
                check("R2", {tag, " undriven before claim"}, {31'b0, ro[c]}, 0);
            end else if (c < base + hold_c) begin
                check("R3", {tag, " prep hold"}, {21'b0, ro[c], rc[c], rd[c]}, {21'b0, 1'b1, 2'b11, 8'h00});
            end else if (c < base + hold_c + n) begin
                check("R4", {tag, " transmit byte"}, {21'b0, ro[c], rc[c], rd[c]},
                      {21'b0, 1'b1, 2'b01, byte_of(c - base - hold_c)});
            end else begin
                k = c - (base + hold_c + n);
                if (trl && k == 0)
                    check("R5", {tag, " closing hold"}, {21'b0, ro[c], rc[c], rd[c]}, {21'b0, 1'b1, 2'b11, trailer});
                else if ((trl && k == 1) || (!trl && k == 0))
                    check(trl ? "R5" : "R6", {tag, " closing idle"}, {21'b0, ro[c], rc[c], rd[c]}, {21'b0, 1'b1, 2'b00, 8'h00});
                else
                    check(trl ? "R5" : "R6", {tag, " released"}, {31'b0, ro[c]}, 0);
            end
            k = base + hold_c + n + (trl ? 1 : 0);
            check("R9", {tag, " done pulse"}, {31'b0, rdone[c]}, {31'b0, (c == k) ? 1'b1 : 1'b0});
        end
        if (!use_last) check("R8", {tag, " underrun consumed all bytes"}, idx, n);
        quiet_inputs();
        repeat (2) @(negedge clk);
    endtask

    // R2: rejected grant never drives, even when tempted
    task automatic t_reject(input string tag, input logic [7:0] g, input logic rv,
                            input logic [2:0] kind, input logic [1:0] rate, input logic beta,
                            input logic [1:0] after_ctl);
        logic seen_oe, seen_ab, seen_rdy;
        req_valid = rv; req_kind = kind; req_rate = rate; req_beta = beta;
        do_grant(g, after_ctl);
        seen_oe = 0; seen_ab = 0; seen_rdy = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            seen_oe |= lk_ctl_oe | lk_d_oe; seen_ab |= tx_abandon;
            pl_valid = 1; hold_req = 1; pl_data = 8'h5A;
            #1;
            seen_rdy |= pl_ready;
        end
        check("R2", {tag, " bus untouched"}, {29'b0, seen_oe, seen_ab, seen_rdy}, 0);
        quiet_inputs();
        repeat (2) @(negedge clk);
    endtask

    // R7: no payload and no hold inside the window
    task automatic t_timeout();
        req_valid = 1; req_kind = 3'b101; req_rate = 2'b01; req_beta = 0;
        do_grant({1'b0, 2'b01, 1'b0, 3'b101, 1'b0}, 2'b00);
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check("R7", "abandon timing", {30'b0, lk_ctl_oe, tx_abandon}, {30'b0, 1'b0, (c == 6) ? 1'b1 : 1'b0});
        end
        quiet_inputs();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_pkt("async S400 direct",  3'b101, 2'b10, 1'b0, 0, 0, 4, 1, 3'b000, 2'b00, 1'b0, 1'b0);
        t_pkt("isoch S800 hold",    3'b010, 2'b11, 1'b1, 2, 3, 3, 1, 3'b001, 2'b10, 1'b1, 1'b0);
        t_pkt("cycstart edge",      3'b110, 2'b00, 1'b0, 5, 1, 1, 1, 3'b000, 2'b00, 1'b0, 1'b1);
        t_pkt("immediate underrun", 3'b111, 2'b01, 1'b0, 1, 0, 2, 0, 3'b110, 2'b01, 1'b0, 1'b1);
        t_reject("speed differs",  {1'b0, 2'b10, 1'b0, 3'b101, 1'b0}, 1, 3'b101, 2'b01, 0, 2'b00);
        t_reject("format differs", {1'b0, 2'b01, 1'b0, 3'b101, 1'b1}, 1, 3'b101, 2'b01, 0, 2'b00);
        t_reject("type differs",   {1'b0, 2'b01, 1'b0, 3'b110, 1'b0}, 1, 3'b101, 2'b01, 0, 2'b00);
        t_reject("reserved type",  {1'b0, 2'b01, 1'b0, 3'b011, 1'b0}, 1, 3'b011, 2'b01, 0, 2'b00);
        t_reject("no request",     {1'b0, 2'b01, 1'b0, 3'b101, 1'b0}, 0, 3'b101, 2'b01, 0, 2'b00);
        t_reject("no idle after",  {1'b0, 2'b01, 1'b0, 3'b101, 1'b0}, 1, 3'b101, 2'b01, 0, 2'b11);
        t_timeout();
        t_pkt("after timeout",     3'b101, 2'b00, 1'b1, 3, 2, 2, 1, 3'b100, 2'b11, 1'b0, 1'b0);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule